// File: doc/BRIEF.md
# Battery Reconnect Interlock Controller

This block decides whether the switch between the battery and the system rail is closed. A host or a push button closes it by holding a request line high for a long, parameterised number of clock ticks (two seconds in the target system). Once the link is closed, a high level on the same line keeps it closed. A low level, which is also what a floating line reads as, opens it on the next clock.

While valid input power is present the request line is ignored and the switch is held open. This stops the battery from being tied to a regulated supply and carrying a circulating current. When input power goes away, a request line that is still high closes the switch at once, with no new hold period. A request line that is low at that moment leaves the switch open, and a full hold is then needed to close it. The request input is expected to be synchronised to the clock already.

Top module: `batt_link_ctrl`

## Requirements
- R1: After a synchronous reset `bat_connect_o` is 0 and no hold time has been accumulated.
- R2: With `pwr_valid_i` low and the switch open, `bat_connect_o` rises after the edge at which `bat_req_i` has been sampled high on HOLD_TICKS consecutive clock edges, and not earlier.
- R3: A low sample of `bat_req_i` before HOLD_TICKS high samples are reached discards the partial hold. A further HOLD_TICKS consecutive high samples are then needed.
- R4: With `pwr_valid_i` low, a closed switch stays closed for as long as `bat_req_i` is sampled high.
- R5: With `pwr_valid_i` low, a low sample of `bat_req_i` (a floating line reads low) makes `bat_connect_o` 0 after that edge.
- R6: A high sample of `pwr_valid_i` makes `bat_connect_o` 0 after that edge, whatever `bat_req_i` is. The request is ignored for as long as power stays valid, however long it is held.
- R7: At the first edge with `pwr_valid_i` low after an edge with it high, a high `bat_req_i` closes the switch immediately, with no hold period.
- R8: At the first edge with `pwr_valid_i` low after an edge with it high, a low `bat_req_i` leaves the switch open. A full hold of HOLD_TICKS is then required.
- R9: Hold time accumulated before `pwr_valid_i` rises is discarded. It does not count toward a later hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bat_req_i | input | 1 | Synchronised battery-on request line; low also stands for floating |
| pwr_valid_i | input | 1 | High while valid input power is present |
| bat_connect_o | output | 1 | High closes the battery switch |

## Verification
On every cycle, the embedded properties check the cycle-level rules. Power forces the switch open on the next cycle. A low request opens it. A held request keeps it closed. The moment power leaves with the request high closes it. The hold counter never exceeds its limit and returns to zero whenever counting is not allowed. Only the directed scenarios can show the exact hold length. They also show that an interrupted hold or a hold cut by power is really forgotten, and that a request held through a long powered period never closes the switch. These properties depend on counting many cycles and comparing the result against an independent expectation.

// File: rtl/batt_link_pkg.sv
package batt_link_pkg;

    typedef enum logic [1:0] {
        LINK_OPEN   = 2'd0,
        LINK_CLOSED = 2'd1,
        LINK_LOCKED = 2'd2
    } link_state_e;

    typedef struct packed {
        logic req;
        logic pwr;
    } link_in_t;

    function automatic link_state_e link_next(
        input link_state_e cur,
        input link_in_t    in,
        input logic        hold_done
    );
        link_state_e nxt;
        nxt = cur;
        if (in.pwr) begin
            nxt = LINK_LOCKED;
        end else begin
            unique case (cur)
                LINK_OPEN:   nxt = hold_done ? LINK_CLOSED : LINK_OPEN;
                LINK_CLOSED: nxt = in.req ? LINK_CLOSED : LINK_OPEN;
                LINK_LOCKED: nxt = in.req ? LINK_CLOSED : LINK_OPEN;
                default:     nxt = LINK_OPEN;
            endcase
        end
        return nxt;
    endfunction

    function automatic logic link_may_count(
        input link_state_e cur,
        input link_in_t    in
    );
        return (cur == LINK_OPEN) && !in.pwr && in.req;
    endfunction

endpackage

// File: rtl/batt_hold_timer.sv
module batt_hold_timer #(
    parameter int HOLD_TICKS = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    output logic hold_done
);
    localparam int CNT_W = $clog2(HOLD_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!count_en || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hold_done = count_en && (cnt == LAST);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST); // R2
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        !count_en |=> cnt == '0); // R3
    AST_CNT_RESET: assert property (@(posedge clk)
        rst |=> cnt == '0); // R1

endmodule

// File: rtl/batt_link_fsm.sv
module batt_link_fsm
    import batt_link_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  link_in_t in_now,
    input  logic     hold_done,
    output logic     count_en,
    output logic     link_closed
);
    link_state_e state, state_nxt;

    always_comb begin
        state_nxt = link_next(state, in_now, hold_done);
        count_en  = link_may_count(state, in_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LINK_OPEN;
        end else begin
            state <= state_nxt;
        end
    end

    assign link_closed = (state == LINK_CLOSED);

    AST_PWR_OPENS: assert property (@(posedge clk) disable iff (rst)
        in_now.pwr |=> !link_closed); // R6
    AST_LOW_OPENS: assert property (@(posedge clk) disable iff (rst)
        (!in_now.pwr && !in_now.req) |=> !link_closed); // R5
    AST_HELD_STAYS: assert property (@(posedge clk) disable iff (rst)
        (link_closed && !in_now.pwr && in_now.req) |=> link_closed); // R4
    AST_RESUME_NOW: assert property (@(posedge clk) disable iff (rst)
        (state == LINK_LOCKED && !in_now.pwr && in_now.req) |=> link_closed); // R7
    AST_RESUME_LOW: assert property (@(posedge clk) disable iff (rst)
        (state == LINK_LOCKED && !in_now.pwr && !in_now.req) |=> !link_closed); // R8
    AST_NO_COUNT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (state == LINK_LOCKED) |-> !count_en); // R9
    AST_RESET_OPEN: assert property (@(posedge clk)
        rst |=> !link_closed); // R1

endmodule

// File: rtl/batt_link_ctrl.sv
module batt_link_ctrl
    import batt_link_pkg::*;
#(
    parameter int HOLD_TICKS = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic bat_req_i,
    input  logic pwr_valid_i,
    output logic bat_connect_o
);
    link_in_t in_now;
    logic     count_en;
    logic     hold_done;

    assign in_now.req = bat_req_i;
    assign in_now.pwr = pwr_valid_i;

    batt_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .count_en  (count_en),
        .hold_done (hold_done)
    );

    batt_link_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .in_now      (in_now),
        .hold_done   (hold_done),
        .count_en    (count_en),
        .link_closed (bat_connect_o)
    );

endmodule

// File: tb/batt_link_ctrl_test.sv
module batt_link_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic pwr = 1'b0;
    logic conn;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    batt_link_ctrl #(.HOLD_TICKS(HOLD)) uut (
        .clk           (clk),
        .rst           (rst),
        .bat_req_i     (req),
        .pwr_valid_i   (pwr),
        .bat_connect_o (conn)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_conn(input logic exp, input string tag);
        checks++;
        if (conn !== exp) begin
            errors++;
            $display("FAIL %s: bat_connect_o=%b expected %b", tag, conn, exp);
        end
    endtask

    task automatic open_link();
        req = 1'b0; pwr = 1'b0;
        cyc(1);
    endtask

    task automatic t_reset();
        rst = 1'b1; req = 1'b1; pwr = 1'b0;
        cyc(3);
        expect_conn(1'b0, "R1 reset");
        rst = 1'b0; req = 1'b0;
        cyc(1);
        req = 1'b1;
        cyc(HOLD - 1);
        expect_conn(1'b0, "R1 no carried hold");
        cyc(1);
        expect_conn(1'b1, "R1 fresh hold");
        open_link();
    endtask

    task automatic t_hold();
        req = 1'b1;
        cyc(HOLD - 1);
        expect_conn(1'b0, "R2 before hold end");
        cyc(1);
        expect_conn(1'b1, "R2 hold end");
        cyc(7);
        expect_conn(1'b1, "R4 held high");
        req = 1'b0;
        cyc(1);
        expect_conn(1'b0, "R5 low opens");
    endtask

    task automatic t_restart();
        req = 1'b1;
        cyc(HOLD - 2);
        req = 1'b0;
        cyc(1);
        expect_conn(1'b0, "R3 drop");
        req = 1'b1;
        cyc(HOLD - 1);
        expect_conn(1'b0, "R3 partial discarded");
        cyc(1);
        expect_conn(1'b1, "R3 full hold");
        open_link();
    endtask

    task automatic t_power();
        pwr = 1'b1; req = 1'b1;
        cyc(3 * HOLD);
        expect_conn(1'b0, "R6 request ignored");
        pwr = 1'b0;
        cyc(1);
        expect_conn(1'b1, "R7 immediate resume");
        pwr = 1'b1;
        cyc(1);
        expect_conn(1'b0, "R6 power opens closed link");
        cyc(2);
        pwr = 1'b0;
        cyc(1);
        expect_conn(1'b1, "R7 resume again");
        open_link();
    endtask

    task automatic t_resume_low();
        req = 1'b0; pwr = 1'b1;
        cyc(3);
        pwr = 1'b0;
        cyc(1);
        expect_conn(1'b0, "R8 stays open");
        req = 1'b1;
        cyc(HOLD - 1);
        expect_conn(1'b0, "R8 needs full hold");
        cyc(1);
        expect_conn(1'b1, "R8 hold completes");
        open_link();
    endtask

    task automatic t_discard();
        req = 1'b1;
        cyc(HOLD - 2);
        expect_conn(1'b0, "R9 partial hold");
        pwr = 1'b1;
        cyc(2);
        req = 1'b0; pwr = 1'b0;
        cyc(1);
        expect_conn(1'b0, "R9 open after power");
        req = 1'b1;
        cyc(HOLD - 1);
        expect_conn(1'b0, "R9 hold discarded");
        cyc(1);
        expect_conn(1'b1, "R9 new hold");
        open_link();
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_hold();
        t_restart();
        t_power();
        t_resume_low();
        t_discard();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule